// File: doc/BRIEF.md
# Load/Store Ordering Matrix

This block tracks up to `NUM_ENT` memory operations in flight and tells the function-unit dependency matrix which of them must wait. Each entry records whether its operation is a load or a store, together with a short compare key. The key is either the upper address bits or a cache-line index, and the caller supplies it. When an operation is allocated, the block compares it against every entry that is still pending. It records a dependency on each such entry that has the opposite type and an equal key. The test is conservative: keys that are equal count as a possible overlap, even if the full addresses differ.

Entries are allocated in program order, one per cycle, into the lowest free slot. Each entry is released through a per-entry done/flush mask. A load entry that depends on an older store raises its read hold. A store entry that depends on an older load raises its write hold. The downstream matrix uses these holds to stop the operation from reading or writing. Once a blocking entry is released, every dependency on it disappears in that same cycle. When every slot is occupied, the block reports full and ignores any allocation.

Top module: `mem_order_matrix`

## Requirements
- R1: An entry allocated as a store (`alloc_st_i`=1) that is still pending raises `hold_rd_o` on every younger load entry with an identical key; `hold_rd_o` is never set on a store entry.
- R2: A pending older load raises `hold_wr_o` on every younger store entry with an identical key; `hold_wr_o` is never set on a load entry.
- R3: Two loads never block each other, and two stores never block each other, even when their keys are equal.
- R4: Keys are compared over all `KEY_W` bits. A difference in any single bit, whether the most or the least significant, means no dependency.
- R5: A dependency is recorded only against entries that were valid and not being released when the new entry was allocated. An entry never becomes held after its allocation cycle, including a slot that is reused by a younger operation.
- R6: While `done_i[k]` is high, every hold caused by entry k is withdrawn in that same cycle. After the clock edge, entry k is invalid, and its dependencies stay cleared.
- R7: `full_o` is high exactly when all `NUM_ENT` entries are valid. An allocation request made while `full_o` is high changes no entry and no hold.
- R8: An accepted allocation occupies the lowest-numbered free slot, which `alloc_idx_o` shows before the edge. `valid_o` has that bit set after the edge.
- R9: After reset, all entries are invalid, both hold vectors are zero, `full_o` is 0 and `alloc_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate a new operation this cycle |
| alloc_st_i | input | 1 | Type of the new operation: 1 = store, 0 = load |
| alloc_key_i | input | KEY_W | Compare key: upper address bits or cache-line index |
| alloc_idx_o | output | $clog2(NUM_ENT) | Slot the next allocation takes |
| full_o | output | 1 | All slots occupied; allocation is ignored |
| done_i | input | NUM_ENT | Per-entry completion or flush |
| valid_o | output | NUM_ENT | Per-entry occupancy |
| hold_rd_o | output | NUM_ENT | Load entry blocked by an older store |
| hold_wr_o | output | NUM_ENT | Store entry blocked by an older load |

## Verification
Some properties are checked on every cycle. A read hold never appears on a store entry, and a write hold never appears on a load entry. Holds appear only at an entry's allocation. A release empties its slot on the next edge. An accepted allocation adds exactly the reported slot, and an allocation made while full leaves the occupancy untouched. Other behaviour can only be shown by the directed scenarios: which pairs block each other (by type, by key bit, by age after a slot is reused) and whether holds are withdrawn within the release cycle.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  typedef enum logic {OP_LD = 1'b0, OP_ST = 1'b1} mem_op_e;
endpackage

// File: rtl/mem_order_pick.sv
module mem_order_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     free_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (free_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign found_o = |free_i;
endmodule

// File: rtl/mem_order_row.sv
module mem_order_row
  import mem_order_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  mem_op_e          op_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [N-1:0]     dep_i,   // older, pending, conflicting peers
  input  logic             kill_i,
  input  logic [N-1:0]     done_i,
  output logic             valid_o,
  output mem_op_e          op_o,
  output logic [KEY_W-1:0] key_o,
  output logic             hold_o
);
  logic [N-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= OP_LD;
      key_o   <= '0;
      blk_q   <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      op_o    <= op_i;
      key_o   <= key_i;
      blk_q   <= dep_i;
    end else begin
      if (kill_i) valid_o <= 1'b0;
      blk_q <= kill_i ? '0 : (blk_q & ~done_i);
    end
  end

  // released blockers stop holding in their release cycle
  assign hold_o = valid_o & |(blk_q & ~done_i);
endmodule

// File: rtl/mem_order_matrix.sv
module mem_order_matrix
  import mem_order_pkg::*;
#(
  parameter int unsigned NUM_ENT = 8,
  parameter int unsigned KEY_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic                       alloc_st_i,
  input  logic [KEY_W-1:0]           alloc_key_i,
  output logic [$clog2(NUM_ENT)-1:0] alloc_idx_o,
  output logic                       full_o,
  input  logic [NUM_ENT-1:0]         done_i,
  output logic [NUM_ENT-1:0]         valid_o,
  output logic [NUM_ENT-1:0]         hold_rd_o,
  output logic [NUM_ENT-1:0]         hold_wr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_ENT);

  mem_op_e            new_op;
  mem_op_e            ent_op  [NUM_ENT];
  logic [KEY_W-1:0]   ent_key [NUM_ENT];
  logic [NUM_ENT-1:0] ent_st;
  logic [NUM_ENT-1:0] ent_hold;
  logic [NUM_ENT-1:0] dep;
  logic [NUM_ENT-1:0] set_row;
  logic               found;
  logic               take;

  assign new_op = alloc_st_i ? OP_ST : OP_LD;

  mem_order_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) i_pick (
    .free_i  (~valid_o),
    .found_o (found),
    .idx_o   (alloc_idx_o)
  );

  assign full_o = ~found;
  assign take   = alloc_i & found;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign set_row[g] = take && (alloc_idx_o == IDX_W'(g));
    assign dep[g]     = valid_o[g] & ~done_i[g] & (ent_op[g] != new_op)
                        & (ent_key[g] == alloc_key_i);
    assign ent_st[g]  = (ent_op[g] == OP_ST);

    mem_order_row #(.N(NUM_ENT), .KEY_W(KEY_W)) i_row (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_row[g]),
      .op_i    (new_op),
      .key_i   (alloc_key_i),
      .dep_i   (dep),
      .kill_i  (done_i[g]),
      .done_i  (done_i),
      .valid_o (valid_o[g]),
      .op_o    (ent_op[g]),
      .key_o   (ent_key[g]),
      .hold_o  (ent_hold[g])
    );
  end

  assign hold_rd_o = ent_hold & ~ent_st;
  assign hold_wr_o = ent_hold & ent_st;
endmodule

// File: rtl/mem_order_matrix_chk.sv
module mem_order_matrix_chk #(
  parameter int unsigned NUM_ENT = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       alloc_i,
  input logic                       full_o,
  input logic [$clog2(NUM_ENT)-1:0] alloc_idx_o,
  input logic [NUM_ENT-1:0]         done_i,
  input logic [NUM_ENT-1:0]         valid_o,
  input logic [NUM_ENT-1:0]         hold_rd_o,
  input logic [NUM_ENT-1:0]         hold_wr_o,
  input logic [NUM_ENT-1:0]         ent_st
);
  // R1
  rd_hold_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_rd_o & (ent_st | ~valid_o)) == '0);

  // R2
  wr_hold_on_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_wr_o & (~ent_st | ~valid_o)) == '0);

  // R5
  hold_only_at_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hold_rd_o | hold_wr_o) & ~$past(hold_rd_o | hold_wr_o)
     & ~(($past(alloc_i) && !$past(full_o)) ? (NUM_ENT'(1) << $past(alloc_idx_o)) : '0)
     & ~$past(done_i)) == '0);

  // R6
  release_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> ((valid_o & $past(done_i)) == '0));

  // R7
  full_ignores_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && full_o) |=> (valid_o == $past(valid_o & ~done_i)));

  // R8
  alloc_adds_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !full_o) |=>
      (valid_o == ($past(valid_o & ~done_i) | (NUM_ENT'(1) << $past(alloc_idx_o)))));

  // R7
  full_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (&valid_o));
endmodule

bind mem_order_matrix mem_order_matrix_chk #(.NUM_ENT(NUM_ENT)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alloc_i     (alloc_i),
  .full_o      (full_o),
  .alloc_idx_o (alloc_idx_o),
  .done_i      (done_i),
  .valid_o     (valid_o),
  .hold_rd_o   (hold_rd_o),
  .hold_wr_o   (hold_wr_o),
  .ent_st      (ent_st)
);

// File: tb/test_mem_order_matrix.sv
module test_mem_order_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int KW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc = 1'b0;
  logic          alloc_st = 1'b0;
  logic [KW-1:0] alloc_key = '0;
  logic [2:0]    alloc_idx;
  logic          full;
  logic [N-1:0]  done = '0;
  logic [N-1:0]  valid;
  logic [N-1:0]  hold_rd;
  logic [N-1:0]  hold_wr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_order_matrix #(.NUM_ENT(N), .KEY_W(KW)) i_mem_order_matrix (
    .clk_i(clk), .rst_ni(rst_n), .alloc_i(alloc), .alloc_st_i(alloc_st),
    .alloc_key_i(alloc_key), .alloc_idx_o(alloc_idx), .full_o(full),
    .done_i(done), .valid_o(valid), .hold_rd_o(hold_rd), .hold_wr_o(hold_wr)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_alloc(input bit st, input logic [KW-1:0] key);
    @(negedge clk);
    alloc = 1'b1; alloc_st = st; alloc_key = key;
    @(negedge clk);
    alloc = 1'b0;
  endtask

  task automatic release_mask(input logic [N-1:0] m);
    @(negedge clk);
    done = m;
    @(negedge clk);
    done = '0;
  endtask

  task automatic t_reset;
    chk("R9 valid", 32'(valid), 0);
    chk("R9 holds", 32'(hold_rd | hold_wr), 0);
    chk("R9 full", 32'(full), 0);
    chk("R9 idx", 32'(alloc_idx), 0);
  endtask

  task automatic t_store_then_load;
    release_mask('1);
    do_alloc(1'b1, 8'h12);
    chk("R8 idx after first", 32'(alloc_idx), 1);
    do_alloc(1'b0, 8'h12);
    chk("R1 hold_rd", 32'(hold_rd), 32'h02);
    chk("R1 hold_wr", 32'(hold_wr), 0);
    chk("R8 valid", 32'(valid), 32'h03);
  endtask

  task automatic t_load_then_store;
    release_mask('1);
    do_alloc(1'b0, 8'h34);
    do_alloc(1'b1, 8'h34);
    chk("R2 hold_wr", 32'(hold_wr), 32'h02);
    chk("R2 hold_rd", 32'(hold_rd), 0);
  endtask

  task automatic t_same_type;
    release_mask('1);
    do_alloc(1'b0, 8'h56);
    do_alloc(1'b0, 8'h56);
    do_alloc(1'b1, 8'h9a);
    do_alloc(1'b1, 8'h9a);
    chk("R3 no holds", 32'(hold_rd | hold_wr), 0);
    chk("R3 valid", 32'(valid), 32'h0f);
  endtask

  task automatic t_key_bits;
    release_mask('1);
    do_alloc(1'b1, 8'h12);
    do_alloc(1'b0, 8'h13);
    do_alloc(1'b0, 8'h92);
    chk("R4 lsb/msb differ", 32'(hold_rd | hold_wr), 0);
  endtask

  task automatic t_age;
    release_mask('1);
    do_alloc(1'b0, 8'h77);
    do_alloc(1'b1, 8'h77);
    chk("R5 older load not held", 32'(hold_rd), 0);
    chk("R2 younger store held", 32'(hold_wr), 32'h02);
    @(negedge clk);
    done = 8'h01;
    #1;
    chk("R6 same-cycle release", 32'(hold_wr), 0);
    @(negedge clk);
    done = '0;
    chk("R6 slot freed", 32'(valid), 32'h02);
    chk("R6 stays clear", 32'(hold_wr), 0);
    do_alloc(1'b0, 8'h77);
    chk("R5 reused slot load held", 32'(hold_rd), 32'h01);
    chk("R5 older store not held", 32'(hold_wr), 0);
  endtask

  task automatic t_release_many;
    release_mask('1);
    do_alloc(1'b1, 8'hab);
    do_alloc(1'b0, 8'hab);
    do_alloc(1'b0, 8'hab);
    chk("R1 two loads held", 32'(hold_rd), 32'h06);
    @(negedge clk);
    done = 8'h01;
    #1;
    chk("R6 holds drop in release cycle", 32'(hold_rd), 0);
    @(negedge clk);
    done = '0;
    chk("R6 valid after release", 32'(valid), 32'h06);
    chk("R6 holds stay clear", 32'(hold_rd), 0);
    chk("R8 lowest free", 32'(alloc_idx), 0);
  endtask

  task automatic t_full;
    release_mask('1);
    for (int k = 0; k < N; k++) do_alloc(1'b0, 8'(k));
    chk("R7 full", 32'(full), 1);
    do_alloc(1'b1, 8'h00);
    chk("R7 ignored valid", 32'(valid), 32'hff);
    chk("R7 ignored holds", 32'(hold_rd | hold_wr), 0);
    release_mask(8'h08);
    chk("R7 not full", 32'(full), 0);
    chk("R8 idx freed slot", 32'(alloc_idx), 3);
    do_alloc(1'b1, 8'h00);
    chk("R8 store into slot3 held", 32'(hold_wr), 32'h08);
    chk("R7 full again", 32'(full), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_store_then_load();
    t_load_then_store();
    t_same_type();
    t_key_bits();
    t_age();
    t_release_many();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule